// File: doc/BRIEF.md
# Cartridge Bank Controller with Real-Time Clock Latch

This block sits between a CPU bus and a cartridge's ROM and RAM arrays. It decodes CPU writes to the ROM address space as control commands. It holds a 7-bit ROM bank number and a 2-bit RAM bank number, and it gates access to the external RAM window at 0xA000-0xBFFF. It also keeps a free-running time-of-day clock: seconds, minutes, hours and a 9-bit day count, advanced by a one-second tick input.

The software view of the clock is a set of five 8-bit snapshot registers, never the live counters. A control write freezes the live time into the snapshot set. Another control write selects either a RAM bank or one of the snapshot registers to appear in the external RAM window. When a snapshot register is selected, window reads and writes reach that register instead of RAM. The RAM array is outside the block. The block presents the flat RAM address and a write strobe, and it returns either the array's read data or its own register data.

Top module: `cart_rtc_ctrl`

## Requirements
- R1: A write with addr[15:13]=0 and data 0x0A enables RAM access, and data 0x00 disables it. Any other data leaves the enable unchanged.
- R2: A write with addr[15:13]=1 sets rom_bank to data[6:0], except that data[6:0]=0 gives bank 1.
- R3: A write with addr[15:13]=2 and data below 4 selects that RAM bank and leaves clock-register mode. ram_addr is {RAM bank, addr[12:0]}.
- R4: A write with addr[15:13]=2 and data from 0x08 to 0x0C enters clock-register mode and selects snapshot register data-8. Data 4-7 or above 0x0C changes nothing.
- R5: A write with addr[15:13]=3 and data 1 takes a snapshot and sets the latched flag, but only while unlatched. Data 0 clears the flag while latched. All other writes to this region do nothing, including data 1 while latched.
- R6: Snapshot layout: register 0 is seconds, 1 is minutes, 2 is hours, 3 is day[7:0]. Register 4 keeps its bits [7:4], takes day[8] in bit 0 and gets zeros in bits [3:1].
- R7: Each cycle with sec_tick high advances the live time by one second. Seconds and minutes wrap at 60, hours wrap at 24, and the 9-bit day count wraps to 0. Without a tick the live time holds.
- R8: In clock-register mode, window reads return the selected snapshot register and window writes never assert ram_we, whatever the RAM enable is.
- R9: A window read returns 0xFF when clock-register mode is off and RAM access is disabled. Any read outside the window also returns 0xFF.
- R10: A CPU write in the window during clock-register mode loads the selected snapshot register.
- R11: After reset: rom_bank=1, RAM bank 0, RAM access disabled, clock-register mode off, unlatched, live time and snapshot registers all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-second tick, one clock cycle per second |
| wr_en | input | 1 | CPU write strobe |
| addr | input | 16 | CPU address |
| wdata | input | 8 | CPU write data |
| ram_rdata | input | 8 | Read data from the external RAM array |
| rd_data | output | 8 | Data returned for a CPU read at addr |
| rom_bank | output | 7 | Selected ROM bank for the switchable ROM area |
| ram_addr | output | 15 | Flat RAM array address |
| ram_we | output | 1 | RAM array write strobe |

## Verification
The checker module tests four properties on every cycle. The ROM bank is never zero. The live counters stay inside their ranges, hold when no tick arrives and wrap the seconds correctly. The latched flag follows the set and clear commands. Clock-register mode blocks RAM writes, and an idle window reads 0xFF. Only the bench scenarios show the rest: the exact snapshot contents after long tick runs (minute and hour rollover into the day count), the preserved upper nibble of register 4, the ignored select and enable codes, and the value read back after a CPU write to a snapshot register.

// File: rtl/crtc_pkg.sv
package crtc_pkg;

    localparam int DATA_W   = 8;
    localparam int CLK_REGS = 5;

    localparam logic [7:0] EN_KEY   = 8'h0A;
    localparam logic [7:0] DIS_KEY  = 8'h00;
    localparam logic [7:0] FILL     = 8'hFF;
    localparam logic [7:0] SEL_LO   = 8'h08;
    localparam logic [7:0] SEL_HI   = 8'h0C;
    localparam logic [2:0] WIN_TAG  = 3'b101;

    typedef enum logic [1:0] {
        RG_ENABLE = 2'd0,
        RG_ROM    = 2'd1,
        RG_SELECT = 2'd2,
        RG_LATCH  = 2'd3
    } ctl_region_e;

    typedef struct packed {
        logic [8:0] day;
        logic [4:0] hr;
        logic [5:0] min;
        logic [5:0] sec;
    } rtc_time_t;

    // Snapshot value for one register; keep is the register's present content.
    function automatic logic [7:0] snap_byte(rtc_time_t t, logic [2:0] idx, logic [7:0] keep);
        case (idx)
            3'd0:    snap_byte = {2'b00, t.sec};
            3'd1:    snap_byte = {2'b00, t.min};
            3'd2:    snap_byte = {3'b000, t.hr};
            3'd3:    snap_byte = t.day[7:0];
            3'd4:    snap_byte = {keep[7:4], 3'b000, t.day[8]};
            default: snap_byte = keep;
        endcase
    endfunction

endpackage

// File: rtl/crtc_decode.sv
module crtc_decode
    import crtc_pkg::*;
#(
    parameter int ROM_BANK_W = 7,
    parameter int RAM_BANK_W = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [2:0]            addr_hi,
    input  logic [DATA_W-1:0]     wdata,
    output logic [ROM_BANK_W-1:0] rom_bank,
    output logic [RAM_BANK_W-1:0] ram_bank,
    output logic                  acc_en,
    output logic                  clk_mode,
    output logic [2:0]            clk_idx,
    output logic                  snap_req,
    output logic                  free_req
);
    localparam int RAM_BANKS = 1 << RAM_BANK_W;

    logic        ctl_wr;
    ctl_region_e region;

    assign ctl_wr   = wr_en && !addr_hi[2];
    assign region   = ctl_region_e'(addr_hi[1:0]);
    assign snap_req = ctl_wr && region == RG_LATCH && wdata == 8'd1;
    assign free_req = ctl_wr && region == RG_LATCH && wdata == 8'd0;

    always_ff @(posedge clk) begin
        if (rst) begin
            rom_bank <= ROM_BANK_W'(1);
            ram_bank <= '0;
            acc_en   <= 1'b0;
            clk_mode <= 1'b0;
            clk_idx  <= '0;
        end else if (ctl_wr) begin
            case (region)
                RG_ENABLE: begin
                    if (wdata == EN_KEY)       acc_en <= 1'b1;
                    else if (wdata == DIS_KEY) acc_en <= 1'b0;
                end
                RG_ROM: begin
                    if (wdata[ROM_BANK_W-1:0] == '0) rom_bank <= ROM_BANK_W'(1);
                    else                             rom_bank <= wdata[ROM_BANK_W-1:0];
                end
                RG_SELECT: begin
                    if (32'(wdata) < RAM_BANKS) begin
                        ram_bank <= wdata[RAM_BANK_W-1:0];
                        clk_mode <= 1'b0;
                    end else if (wdata >= SEL_LO && wdata <= SEL_HI) begin
                        clk_idx  <= 3'(wdata - SEL_LO);
                        clk_mode <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/crtc_live.sv
module crtc_live
    import crtc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    output rtc_time_t now
);
    always_ff @(posedge clk) begin
        if (rst) begin
            now <= '0;
        end else if (tick) begin
            if (now.sec == 6'd59) begin
                now.sec <= '0;
                if (now.min == 6'd59) begin
                    now.min <= '0;
                    if (now.hr == 5'd23) begin
                        now.hr  <= '0;
                        now.day <= now.day + 9'd1;
                    end else begin
                        now.hr <= now.hr + 5'd1;
                    end
                end else begin
                    now.min <= now.min + 6'd1;
                end
            end else begin
                now.sec <= now.sec + 6'd1;
            end
        end
    end
endmodule

// File: rtl/crtc_snap.sv
module crtc_snap
    import crtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  rtc_time_t         now,
    input  logic              snap_req,
    input  logic              free_req,
    input  logic              cpu_wr,
    input  logic [2:0]        idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_byte,
    output logic              latched
);
    logic [DATA_W-1:0] snap_q [CLK_REGS];
    logic              take;

    assign take = snap_req && !latched;

    always_ff @(posedge clk) begin
        if (rst)                      latched <= 1'b0;
        else if (take)                latched <= 1'b1;
        else if (free_req && latched) latched <= 1'b0;
    end

    for (genvar g = 0; g < CLK_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)                            snap_q[g] <= '0;
            else if (take)                      snap_q[g] <= snap_byte(now, 3'(g), snap_q[g]);
            else if (cpu_wr && idx == 3'(g))    snap_q[g] <= wdata;
        end
    end

    always_comb begin
        rd_byte = FILL;
        for (int i = 0; i < CLK_REGS; i++) begin
            if (idx == 3'(i)) rd_byte = snap_q[i];
        end
    end
endmodule

// File: rtl/cart_rtc_ctrl.sv
module cart_rtc_ctrl
    import crtc_pkg::*;
#(
    parameter int ROM_BANK_W = 7,
    parameter int RAM_BANK_W = 2,
    parameter int ADDR_W     = 16
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             sec_tick,
    input  logic                             wr_en,
    input  logic [ADDR_W-1:0]                addr,
    input  logic [7:0]                       wdata,
    input  logic [7:0]                       ram_rdata,
    output logic [7:0]                       rd_data,
    output logic [ROM_BANK_W-1:0]            rom_bank,
    output logic [RAM_BANK_W+ADDR_W-4:0]     ram_addr,
    output logic                             ram_we
);
    localparam int OFS_W = ADDR_W - 3;

    logic [RAM_BANK_W-1:0] ram_bank;
    logic                  acc_en;
    logic                  clk_mode;
    logic [2:0]            clk_idx;
    logic                  snap_req;
    logic                  free_req;
    logic                  latched;
    logic                  in_win;
    logic [7:0]            clk_byte;
    rtc_time_t             live_t;

    assign in_win = addr[ADDR_W-1 -: 3] == WIN_TAG;

    crtc_decode #(.ROM_BANK_W(ROM_BANK_W), .RAM_BANK_W(RAM_BANK_W)) u_dec (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr_hi(addr[ADDR_W-1 -: 3]),
        .wdata(wdata), .rom_bank(rom_bank), .ram_bank(ram_bank), .acc_en(acc_en),
        .clk_mode(clk_mode), .clk_idx(clk_idx), .snap_req(snap_req), .free_req(free_req)
    );

    crtc_live u_live (.clk(clk), .rst(rst), .tick(sec_tick), .now(live_t));

    crtc_snap u_snap (
        .clk(clk), .rst(rst), .now(live_t), .snap_req(snap_req), .free_req(free_req),
        .cpu_wr(wr_en && in_win && clk_mode), .idx(clk_idx), .wdata(wdata),
        .rd_byte(clk_byte), .latched(latched)
    );

    assign ram_addr = {ram_bank, addr[OFS_W-1:0]};
    assign ram_we   = wr_en && in_win && acc_en && !clk_mode;

    always_comb begin
        rd_data = FILL;
        if (in_win) begin
            if (clk_mode)    rd_data = clk_byte;
            else if (acc_en) rd_data = ram_rdata;
        end
    end
endmodule

// File: rtl/crtc_chk.sv
module crtc_chk
    import crtc_pkg::*;
#(
    parameter int ROM_BANK_W = 7,
    parameter int ADDR_W     = 16
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  sec_tick,
    input logic                  wr_en,
    input logic [ADDR_W-1:0]     addr,
    input logic [7:0]            wdata,
    input logic [7:0]            rd_data,
    input logic [ROM_BANK_W-1:0] rom_bank,
    input logic                  ram_we,
    input logic                  acc_en,
    input logic                  clk_mode,
    input logic                  latched,
    input rtc_time_t             live_t
);
    logic win;
    logic latch_wr;
    assign win      = addr[ADDR_W-1 -: 3] == WIN_TAG;
    assign latch_wr = wr_en && addr[ADDR_W-1 -: 3] == 3'd3;

    p_rom_nonzero_r2: assert property (@(posedge clk) disable iff (rst)
        rom_bank != '0);

    p_live_range_r7: assert property (@(posedge clk) disable iff (rst)
        live_t.sec < 6'd60 && live_t.min < 6'd60 && live_t.hr < 5'd24);

    p_sec_wrap_r7: assert property (@(posedge clk) disable iff (rst)
        sec_tick && live_t.sec == 6'd59 |=> live_t.sec == 6'd0);

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !sec_tick |=> $stable(live_t));

    p_latch_set_r5: assert property (@(posedge clk) disable iff (rst)
        latch_wr && wdata == 8'd1 && !latched |=> latched);

    p_latch_clear_r5: assert property (@(posedge clk) disable iff (rst)
        latch_wr && wdata == 8'd0 && latched |=> !latched);

    p_latch_other_r5: assert property (@(posedge clk) disable iff (rst)
        !(latch_wr && (wdata == 8'd0 || wdata == 8'd1)) |=> $stable(latched));

    p_clock_priority_r8: assert property (@(posedge clk) disable iff (rst)
        win && clk_mode |-> !ram_we);

    p_idle_ff_r9: assert property (@(posedge clk) disable iff (rst)
        win && !clk_mode && !acc_en |-> rd_data == FILL);
endmodule

bind cart_rtc_ctrl crtc_chk #(.ROM_BANK_W(ROM_BANK_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .sec_tick(sec_tick), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rd_data(rd_data), .rom_bank(rom_bank), .ram_we(ram_we),
    .acc_en(acc_en), .clk_mode(clk_mode), .latched(latched), .live_t(live_t)
);

// File: tb/cart_rtc_ctrl_tb_top.sv
`timescale 1ns/1ps
module cart_rtc_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sec_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] addr = 16'h0000;
    logic [7:0]  wdata = 8'h00;
    logic [7:0]  ram_rdata;
    logic [7:0]  rd_data;
    logic [6:0]  rom_bank;
    logic [14:0] ram_addr;
    logic        ram_we;

    int checks = 0;
    int errors = 0;
    int ticks  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    assign ram_rdata = addr[7:0] ^ 8'hC3;

    cart_rtc_ctrl dut_i (
        .clk(clk), .rst(rst), .sec_tick(sec_tick), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .ram_rdata(ram_rdata), .rd_data(rd_data), .rom_bank(rom_bank),
        .ram_addr(ram_addr), .ram_we(ram_we)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [15:0] a, input logic [7:0] exp);
        @(negedge clk);
        addr = a;
        #1;
        chk(tag, rd_data, exp);
    endtask

    task automatic run_ticks(input int n);
        @(negedge clk);
        sec_tick = 1'b1;
        repeat (n) @(posedge clk);
        @(negedge clk);
        sec_tick = 1'b0;
        ticks += n;
    endtask

    function automatic logic [7:0] exp_snap(input int idx, input int t, input logic [7:0] keep);
        int d;
        d = (t / 86400) % 512;
        case (idx)
            0: exp_snap = 8'(t % 60);
            1: exp_snap = 8'((t / 60) % 60);
            2: exp_snap = 8'((t / 3600) % 24);
            3: exp_snap = 8'(d % 256);
            default: exp_snap = {keep[7:4], 3'b000, 1'(d / 256)};
        endcase
    endfunction

    task automatic read_snaps(input string tag, input int t, input logic [7:0] keep);
        for (int i = 0; i < 5; i++) begin
            bus_wr(16'h4000, 8'(8 + i));
            rd_chk($sformatf("%s R6 reg%0d", tag, i), 16'hA000, exp_snap(i, t, keep));
        end
    endtask

    task automatic t_reset();
        chk("R11 rom_bank after reset", rom_bank, 7'd1);
        rd_chk("R11 R9 window disabled after reset", 16'hA123, 8'hFF);
        chk("R11 ram_addr bank 0", ram_addr, 15'h0123);
        chk("R11 ram_we idle", ram_we, 1'b0);
    endtask

    task automatic t_enable();
        bus_wr(16'h0000, 8'h0A);
        rd_chk("R1 enabled read", 16'hA123, 8'h23 ^ 8'hC3);
        bus_wr(16'h1FFF, 8'h05);
        rd_chk("R1 other value ignored", 16'hA155, 8'h55 ^ 8'hC3);
        bus_wr(16'h0000, 8'h00);
        rd_chk("R1 R9 disabled read", 16'hA155, 8'hFF);
        bus_wr(16'h1000, 8'h0B);
        rd_chk("R1 0x0B ignored", 16'hA155, 8'hFF);
        rd_chk("R9 outside window", 16'h8000, 8'hFF);
        bus_wr(16'h0000, 8'h0A);
    endtask

    task automatic t_rom();
        bus_wr(16'h2000, 8'h00);
        chk("R2 zero maps to 1", rom_bank, 7'd1);
        bus_wr(16'h3FFF, 8'h85);
        chk("R2 low 7 bits", rom_bank, 7'h05);
        bus_wr(16'h2000, 8'h7F);
        chk("R2 max bank", rom_bank, 7'h7F);
        bus_wr(16'h2000, 8'h80);
        chk("R2 0x80 maps to 1", rom_bank, 7'd1);
    endtask

    task automatic t_ram_bank();
        bus_wr(16'h4000, 8'h02);
        rd_chk("R3 bank 2 read", 16'hA123, 8'h23 ^ 8'hC3);
        chk("R3 ram_addr bank 2", ram_addr, {2'b10, 13'h0123});
        bus_wr(16'h5FFF, 8'h03);
        #1 chk("R3 ram_addr bank 3", ram_addr, {2'b11, 13'h1FFF});
        bus_wr(16'h4000, 8'h05);
        rd_chk("R4 value 5 ignored", 16'hB456, 8'h56 ^ 8'hC3);
        chk("R4 bank kept after 5", ram_addr, {2'b11, 13'h1456});
        bus_wr(16'h4000, 8'h0D);
        rd_chk("R4 value 0x0D ignored", 16'hA010, 8'h10 ^ 8'hC3);
        chk("R4 bank kept after 0x0D", ram_addr, {2'b11, 13'h0010});
        @(negedge clk);
        addr = 16'hB000; wdata = 8'h11; wr_en = 1'b1;
        #1 chk("R8 ram_we in RAM mode", ram_we, 1'b1);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic t_clock_regs();
        bus_wr(16'h4000, 8'h08);
        @(negedge clk);
        addr = 16'hA000; wdata = 8'h2A; wr_en = 1'b1;
        #1 chk("R8 no ram_we in clock mode", ram_we, 1'b0);
        @(negedge clk);
        wr_en = 1'b0;
        rd_chk("R10 reg0 written", 16'hA000, 8'h2A);
        bus_wr(16'h0000, 8'h00);
        rd_chk("R8 clock read with RAM disabled", 16'hBFFF, 8'h2A);
        bus_wr(16'h4000, 8'h0C);
        bus_wr(16'hA000, 8'hF7);
        rd_chk("R10 reg4 written", 16'hA000, 8'hF7);
        bus_wr(16'h4000, 8'h0D);
        rd_chk("R4 0x0D keeps reg4", 16'hA000, 8'hF7);
        bus_wr(16'h4000, 8'h06);
        rd_chk("R4 6 keeps reg4", 16'hA000, 8'hF7);
        bus_wr(16'h4000, 8'h08);
        rd_chk("R4 reg0 reselected", 16'hA000, 8'h2A);
        bus_wr(16'h4000, 8'h01);
        rd_chk("R3 leaves clock mode", 16'hA000, 8'hFF);
        bus_wr(16'h0000, 8'h0A);
        rd_chk("R3 RAM read after clock mode", 16'hA077, 8'h77 ^ 8'hC3);
    endtask

    task automatic t_latch();
        run_ticks(75);
        bus_wr(16'h6000, 8'h00);
        bus_wr(16'h6000, 8'h01);
        read_snaps("R5 R7 first snapshot", 75, 8'hF7);
        run_ticks(3600);
        bus_wr(16'h6000, 8'h01);
        bus_wr(16'h4000, 8'h0A);
        rd_chk("R5 set while latched ignored", 16'hA000, 8'h00);
        bus_wr(16'h7FFF, 8'h02);
        bus_wr(16'h6000, 8'h00);
        rd_chk("R5 clear keeps values", 16'hA000, 8'h00);
        bus_wr(16'h6000, 8'h01);
        read_snaps("R5 R7 second snapshot", 3675, 8'hF0);
        bus_wr(16'h4000, 8'h08);
        bus_wr(16'hA000, 8'h33);
        rd_chk("R10 reg0 overwrite", 16'hA000, 8'h33);
        bus_wr(16'h4000, 8'h0C);
        bus_wr(16'hA000, 8'h5E);
        run_ticks(86400);
        bus_wr(16'h6000, 8'h00);
        bus_wr(16'h6000, 8'h01);
        read_snaps("R6 R7 day rollover", 90075, 8'h5E);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_enable();
        t_rom();
        t_ram_bank();
        t_clock_regs();
        t_latch();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule